// File: doc/BRIEF.md
# Table-Driven Waveform Generator

This block emits one signed sample per clock. The samples come from a table that holds exactly one period of a waveform and lives in an external single-port RAM. The block drives the RAM's read address and read enable. The RAM returns read data one clock later together with a read-valid strobe, and the block qualifies every sample with that strobe. Four operating modes are available:

- **off**: no output.
- **computed**: a phase accumulator steps through the table at a programmable normalised frequency, starting at a programmable phase.
- **one-shot playback**: walks the first N table entries once.
- **looped playback**: walks the first N entries without end.

Every sample passes through a registered gain stage. That stage rounds the result, clips it to a symmetric range and flags any clipping.

The five control settings are mode, step, gain, count and phase. They are held in an active copy, which is loaded only on a one-cycle restart pulse. The active copy is driven out for readback.

The sequencer has five states:

| State | Behaviour |
|---|---|
| `ST_OFF` | no reads |
| `ST_CALC` | accumulator-driven reads |
| `ST_SINGLE` | one-shot reads |
| `ST_REPEAT` | looped reads |
| `ST_DONE` | playback finished, no reads |

The state transitions are:

- **Restart**: from any state, to the state the restart mode selects. A playback mode with an effective count of zero goes straight to `ST_DONE`.
- **End of one-shot**: from `ST_SINGLE` to `ST_DONE`, after the read of index N-1 is issued.
- **Hold**: every other state keeps its state until the next restart.

Top module: `wg_gen`

## Requirements
- R1: The mode code is 0 for off, 1 for computed, 2 for one-shot and 3 for looped. While the active mode is off, `tbl_rden` stays low. From two cycles after an off restart, `wave_val`, `wave_sync` and `wave_ovr` are low and `wave_dat` is 0. Whenever `wave_val` is low, `wave_dat` is 0.
- R2: The `act_*` outputs load all five `cfg_*` inputs on the clock edge that samples `restart` high, so they are visible one cycle later. Without a restart they do not change, whatever the `cfg_*` inputs do.
- R3: Table data is taken only when `tbl_rdval` is high. The output stage is registered once after the read returns, so a sample whose address is issued in cycle t appears on `wave_dat` in cycle t+2.
- R4: In one-shot mode, the first sample appears two cycles after the restart edge. The block then outputs table indices 0 to N-1 on consecutive cycles, and after that `wave_val` stays low until the next restart.
- R5: In looped mode, the block outputs indices 0 to N-1 without gaps and without end.
- R6: The effective count is `cfg_count` clipped to the table depth of 64. An effective count of 0 produces no valid output in either playback mode.
- R7: In computed mode, the accumulator is 16 bits wide and advances by `act_freq[15:0]` each cycle. A `cfg_freq` value of 65536 equals the sample rate. The table index is accumulator bits [15:10]. At restart the accumulator starts at floor(phase*65536/360), where phase is in degrees of the stored period.
- R8: In computed mode, a step equal to the sample rate or any integer multiple of it gives a constant output. That constant is the table entry selected by the phase.
- R9: The output is round(sample*gain/256), computed as floor((sample*gain+128)/256). A gain of 256 reproduces the table exactly. Results are clipped to the range -127 to +127, so -128 never appears.
- R10: `wave_ovr` is high in exactly the cycles whose valid sample was clipped.
- R11: `wave_sync` marks the sample read from index 0 in the playback modes. In computed mode it marks the first sample after a restart, and every sample whose accumulator value is below that of the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| restart | input | 1 | one-cycle pulse that loads the settings and restarts |
| cfg_mode | input | 2 | requested mode |
| cfg_freq | input | 18 | requested step, 65536 = sample rate |
| cfg_ampl | input | 10 | requested gain, 256 = unity |
| cfg_count | input | 7 | requested playback length |
| cfg_phase | input | 9 | requested start phase in degrees |
| act_mode | output | 2 | active mode |
| act_freq | output | 18 | active step |
| act_ampl | output | 10 | active gain |
| act_count | output | 7 | active length as written |
| act_phase | output | 9 | active phase |
| tbl_addr | output | 6 | table read address |
| tbl_rden | output | 1 | table read enable |
| tbl_rdata | input | 8 | table read data, signed |
| tbl_rdval | input | 1 | table read data valid |
| wave_dat | output | 8 | signed output sample |
| wave_val | output | 1 | output sample valid |
| wave_sync | output | 1 | period start marker |
| wave_ovr | output | 1 | sample was clipped |

## Verification
A wrong sequencer state shows up at the table port immediately: a read enable in off or finished states, or an address off the expected 0..N-1 walk. It reaches `wave_dat` and `wave_val` two cycles later as a misplaced or missing sample. A bad accumulator start or step shows as a wrong table value or a misplaced sync on the very first computed sample. A stale or early settings capture shows on the `act_*` outputs one cycle after the restart edge. A fault in the gain stage shows in the same cycle the clipped sample leaves, as a value outside ±127 or a `wave_ovr` that disagrees with clipping.

// File: rtl/wg_pkg.sv
package wg_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_CALC   = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_REPEAT = 2'd3
    } wg_mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CALC,
        ST_SINGLE,
        ST_REPEAT,
        ST_DONE
    } wg_state_e;

endpackage

// File: rtl/wg_ctrl_capture.sv
module wg_ctrl_capture #(
    parameter int FREQ_W  = 18,
    parameter int AMPL_W  = 10,
    parameter int CNT_W   = 7,
    parameter int PHASE_W = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [1:0]         cfg_mode,
    input  logic [FREQ_W-1:0]  cfg_freq,
    input  logic [AMPL_W-1:0]  cfg_ampl,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic [PHASE_W-1:0] cfg_phase,
    output logic [1:0]         act_mode,
    output logic [FREQ_W-1:0]  act_freq,
    output logic [AMPL_W-1:0]  act_ampl,
    output logic [CNT_W-1:0]   act_count,
    output logic [PHASE_W-1:0] act_phase
);

    // Settings are held until the next restart pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode  <= '0;
            act_freq  <= '0;
            act_ampl  <= '0;
            act_count <= '0;
            act_phase <= '0;
        end else if (restart) begin
            act_mode  <= cfg_mode;
            act_freq  <= cfg_freq;
            act_ampl  <= cfg_ampl;
            act_count <= cfg_count;
            act_phase <= cfg_phase;
        end
    end

endmodule

// File: rtl/wg_seq.sv
module wg_seq
    import wg_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int ACC_W   = 16,
    parameter int CNT_W   = 7,
    parameter int PHASE_W = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [1:0]         cfg_mode,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic [PHASE_W-1:0] cfg_phase,
    input  logic [ACC_W-1:0]   step,
    output logic [ADDR_W-1:0]  tbl_addr,
    output logic               tbl_rden,
    output logic               issue_sync
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int NUM_W = ACC_W + PHASE_W;

    wg_state_e         state_q, state_d;
    logic [ADDR_W-1:0] pos_q;
    logic [ADDR_W-1:0] last_q;
    logic [ACC_W-1:0]  acc_q;
    logic              first_q;
    logic              wrap_q;

    logic [CNT_W-1:0]  eff_cnt;
    logic              cnt_empty;
    logic [ACC_W:0]    acc_sum;

    // Degrees of the stored period to initial accumulator value.
    function automatic logic [ACC_W-1:0] phase_to_acc(input logic [PHASE_W-1:0] ph);
        logic [NUM_W-1:0] num;
        num = {ph, {ACC_W{1'b0}}};
        return ACC_W'(num / NUM_W'(360));
    endfunction

    always_comb begin
        eff_cnt   = (cfg_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cfg_count;
        cnt_empty = (eff_cnt == '0);
        acc_sum   = {1'b0, acc_q} + {1'b0, step};
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (restart) begin
            unique case (wg_mode_e'(cfg_mode))
                MODE_OFF:    state_d = ST_OFF;
                MODE_CALC:   state_d = ST_CALC;
                MODE_SINGLE: state_d = cnt_empty ? ST_DONE : ST_SINGLE;
                MODE_REPEAT: state_d = cnt_empty ? ST_DONE : ST_REPEAT;
            endcase
        end else begin
            unique case (state_q)
                ST_SINGLE: if (pos_q == last_q) state_d = ST_DONE;
                ST_OFF, ST_CALC, ST_REPEAT, ST_DONE: state_d = state_q;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    // Address and accumulator registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            last_q  <= '0;
            acc_q   <= '0;
            first_q <= 1'b0;
            wrap_q  <= 1'b0;
        end else if (restart) begin
            pos_q   <= '0;
            last_q  <= ADDR_W'(eff_cnt - CNT_W'(1));
            acc_q   <= phase_to_acc(cfg_phase);
            first_q <= 1'b1;
            wrap_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CALC: begin
                    acc_q   <= acc_sum[ACC_W-1:0];
                    wrap_q  <= acc_sum[ACC_W];
                    first_q <= 1'b0;
                end
                ST_SINGLE, ST_REPEAT: begin
                    pos_q   <= (pos_q == last_q) ? '0 : pos_q + ADDR_W'(1);
                    first_q <= 1'b0;
                end
                ST_OFF, ST_DONE: first_q <= 1'b0;
                default:         first_q <= 1'b0;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        tbl_rden   = 1'b0;
        tbl_addr   = pos_q;
        issue_sync = 1'b0;
        unique case (state_q)
            ST_CALC: begin
                tbl_rden   = 1'b1;
                tbl_addr   = acc_q[ACC_W-1 -: ADDR_W];
                issue_sync = first_q | wrap_q;
            end
            ST_SINGLE, ST_REPEAT: begin
                tbl_rden   = 1'b1;
                issue_sync = (pos_q == '0);
            end
            ST_OFF, ST_DONE: tbl_rden = 1'b0;
            default:         tbl_rden = 1'b0;
        endcase
    end

endmodule

// File: rtl/wg_scale.sv
module wg_scale #(
    parameter int DAT_W     = 8,
    parameter int AMPL_W    = 10,
    parameter int AMPL_FRAC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DAT_W-1:0]  in_data,
    input  logic              in_val,
    input  logic              in_sync,
    input  logic [AMPL_W-1:0] gain,
    output logic [DAT_W-1:0]  out_dat,
    output logic              out_val,
    output logic              out_sync,
    output logic              out_ovr
);

    localparam int PW = DAT_W + AMPL_W + 1;
    localparam logic signed [PW-1:0] HI   = PW'((1 << (DAT_W - 1)) - 1);
    localparam logic signed [PW-1:0] LO   = -HI;
    localparam logic signed [PW-1:0] HALF = PW'(1 << (AMPL_FRAC - 1));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic                 clip_hi;
    logic                 clip_lo;

    always_comb begin
        prod    = $signed({{(PW - DAT_W){in_data[DAT_W-1]}}, in_data})
                * $signed({{(PW - AMPL_W){1'b0}}, gain});
        rnd     = (prod + HALF) >>> AMPL_FRAC;
        clip_hi = (rnd > HI);
        clip_lo = (rnd < LO);
    end

    always_ff @(posedge clk) begin
        if (rst || !in_val) begin
            out_dat  <= '0;
            out_val  <= 1'b0;
            out_sync <= 1'b0;
            out_ovr  <= 1'b0;
        end else begin
            out_val  <= 1'b1;
            out_sync <= in_sync;
            out_ovr  <= clip_hi | clip_lo;
            if (clip_hi)      out_dat <= HI[DAT_W-1:0];
            else if (clip_lo) out_dat <= LO[DAT_W-1:0];
            else              out_dat <= rnd[DAT_W-1:0];
        end
    end

endmodule

// File: rtl/wg_gen.sv
module wg_gen #(
    parameter int ADDR_W    = 6,
    parameter int DAT_W     = 8,
    parameter int ACC_W     = 16,
    parameter int FREQ_W    = ACC_W + 2,
    parameter int AMPL_W    = 10,
    parameter int AMPL_FRAC = 8,
    parameter int CNT_W     = ADDR_W + 1,
    parameter int PHASE_W   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [1:0]         cfg_mode,
    input  logic [FREQ_W-1:0]  cfg_freq,
    input  logic [AMPL_W-1:0]  cfg_ampl,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic [PHASE_W-1:0] cfg_phase,
    output logic [1:0]         act_mode,
    output logic [FREQ_W-1:0]  act_freq,
    output logic [AMPL_W-1:0]  act_ampl,
    output logic [CNT_W-1:0]   act_count,
    output logic [PHASE_W-1:0] act_phase,
    output logic [ADDR_W-1:0]  tbl_addr,
    output logic               tbl_rden,
    input  logic [DAT_W-1:0]   tbl_rdata,
    input  logic               tbl_rdval,
    output logic [DAT_W-1:0]   wave_dat,
    output logic               wave_val,
    output logic               wave_sync,
    output logic               wave_ovr
);

    logic issue_sync;
    logic sync_ret;

    wg_ctrl_capture #(
        .FREQ_W (FREQ_W),
        .AMPL_W (AMPL_W),
        .CNT_W  (CNT_W),
        .PHASE_W(PHASE_W)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .cfg_mode (cfg_mode),
        .cfg_freq (cfg_freq),
        .cfg_ampl (cfg_ampl),
        .cfg_count(cfg_count),
        .cfg_phase(cfg_phase),
        .act_mode (act_mode),
        .act_freq (act_freq),
        .act_ampl (act_ampl),
        .act_count(act_count),
        .act_phase(act_phase)
    );

    wg_seq #(
        .ADDR_W (ADDR_W),
        .ACC_W  (ACC_W),
        .CNT_W  (CNT_W),
        .PHASE_W(PHASE_W)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .cfg_mode  (cfg_mode),
        .cfg_count (cfg_count),
        .cfg_phase (cfg_phase),
        .step      (act_freq[ACC_W-1:0]),
        .tbl_addr  (tbl_addr),
        .tbl_rden  (tbl_rden),
        .issue_sync(issue_sync)
    );

    // Sync tag travels alongside the one-cycle table read.
    always_ff @(posedge clk) begin
        if (rst) sync_ret <= 1'b0;
        else     sync_ret <= issue_sync;
    end

    wg_scale #(
        .DAT_W    (DAT_W),
        .AMPL_W   (AMPL_W),
        .AMPL_FRAC(AMPL_FRAC)
    ) scale_i (
        .clk     (clk),
        .rst     (rst),
        .in_data (tbl_rdata),
        .in_val  (tbl_rdval),
        .in_sync (sync_ret),
        .gain    (act_ampl),
        .out_dat (wave_dat),
        .out_val (wave_val),
        .out_sync(wave_sync),
        .out_ovr (wave_ovr)
    );

endmodule

// File: rtl/wg_gen_checker.sv
module wg_gen_checker #(
    parameter int DAT_W   = 8,
    parameter int FREQ_W  = 18,
    parameter int AMPL_W  = 10,
    parameter int CNT_W   = 7,
    parameter int PHASE_W = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               restart,
    input logic [1:0]         cfg_mode,
    input logic [FREQ_W-1:0]  cfg_freq,
    input logic [1:0]         act_mode,
    input logic [FREQ_W-1:0]  act_freq,
    input logic [AMPL_W-1:0]  act_ampl,
    input logic [CNT_W-1:0]   act_count,
    input logic [PHASE_W-1:0] act_phase,
    input logic               tbl_rden,
    input logic               tbl_rdval,
    input logic [DAT_W-1:0]   wave_dat,
    input logic               wave_val,
    input logic               wave_sync,
    input logic               wave_ovr
);

    localparam logic [DAT_W-1:0] POS_LIM = DAT_W'((1 << (DAT_W - 1)) - 1);
    localparam logic [DAT_W-1:0] NEG_LIM = DAT_W'(-((1 << (DAT_W - 1)) - 1));
    localparam logic [DAT_W-1:0] MOST_NEG = DAT_W'(1 << (DAT_W - 1));

    p_off_no_read_r1: assert property (@(posedge clk) disable iff (rst)
        (act_mode == 2'd0) |-> !tbl_rden);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !wave_val |-> (wave_dat == '0 && !wave_sync && !wave_ovr));

    p_act_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !restart |=> ($stable(act_mode) && $stable(act_freq) && $stable(act_ampl)
                      && $stable(act_count) && $stable(act_phase)));

    p_act_load_r2: assert property (@(posedge clk) disable iff (rst)
        restart |=> (act_mode == $past(cfg_mode) && act_freq == $past(cfg_freq)));

    p_read_to_out_r3: assert property (@(posedge clk) disable iff (rst)
        tbl_rdval |=> wave_val);

    p_no_read_no_out_r3: assert property (@(posedge clk) disable iff (rst)
        !tbl_rdval |=> !wave_val);

    p_sym_range_r9: assert property (@(posedge clk) disable iff (rst)
        wave_val |-> (wave_dat != MOST_NEG));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        wave_ovr |-> (wave_dat == POS_LIM || wave_dat == NEG_LIM));

    p_sync_valid_r11: assert property (@(posedge clk) disable iff (rst)
        wave_sync |-> wave_val);

endmodule

bind wg_gen wg_gen_checker #(
    .DAT_W  (DAT_W),
    .FREQ_W (FREQ_W),
    .AMPL_W (AMPL_W),
    .CNT_W  (CNT_W),
    .PHASE_W(PHASE_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .cfg_mode (cfg_mode),
    .cfg_freq (cfg_freq),
    .act_mode (act_mode),
    .act_freq (act_freq),
    .act_ampl (act_ampl),
    .act_count(act_count),
    .act_phase(act_phase),
    .tbl_rden (tbl_rden),
    .tbl_rdval(tbl_rdval),
    .wave_dat (wave_dat),
    .wave_val (wave_val),
    .wave_sync(wave_sync),
    .wave_ovr (wave_ovr)
);

// File: tb/wg_gen_tb_top.sv
`timescale 1ns/1ps
module wg_gen_tb_top;

    localparam int ADDR_W = 6;
    localparam int DEPTH  = 64;
    localparam int UNIT   = 65536;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [17:0] cfg_freq = '0;
    logic [9:0]  cfg_ampl = '0;
    logic [6:0]  cfg_count = '0;
    logic [8:0]  cfg_phase = '0;
    logic [1:0]  act_mode;
    logic [17:0] act_freq;
    logic [9:0]  act_ampl;
    logic [6:0]  act_count;
    logic [8:0]  act_phase;
    logic [5:0]  tbl_addr;
    logic        tbl_rden;
    logic [7:0]  tbl_rdata = '0;
    logic        tbl_rdval = 1'b0;
    logic [7:0]  wave_dat;
    logic        wave_val;
    logic        wave_sync;
    logic        wave_ovr;

    int  tbl [DEPTH];
    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    wg_gen dut_i (
        .clk(clk), .rst(rst), .restart(restart),
        .cfg_mode(cfg_mode), .cfg_freq(cfg_freq), .cfg_ampl(cfg_ampl),
        .cfg_count(cfg_count), .cfg_phase(cfg_phase),
        .act_mode(act_mode), .act_freq(act_freq), .act_ampl(act_ampl),
        .act_count(act_count), .act_phase(act_phase),
        .tbl_addr(tbl_addr), .tbl_rden(tbl_rden),
        .tbl_rdata(tbl_rdata), .tbl_rdval(tbl_rdval),
        .wave_dat(wave_dat), .wave_val(wave_val),
        .wave_sync(wave_sync), .wave_ovr(wave_ovr)
    );

    // Behavioural table RAM, one clock read latency.
    always @(posedge clk) begin
        tbl_rdval <= tbl_rden;
        tbl_rdata <= 8'(tbl[tbl_addr]);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int scaled(input int t, input int a);
        int r;
        r = (t * a + 128) >>> 8;
        if (r > 127)  r = 127;
        if (r < -127) r = -127;
        return r;
    endfunction

    function automatic bit clipped(input int t, input int a);
        int r;
        r = (t * a + 128) >>> 8;
        return (r > 127) || (r < -127);
    endfunction

    task automatic do_restart(input int m, input int f, input int a, input int c, input int p);
        @(negedge clk);
        cfg_mode  = 2'(m);
        cfg_freq  = 18'(f);
        cfg_ampl  = 10'(a);
        cfg_count = 7'(c);
        cfg_phase = 9'(p);
        restart   = 1'b1;
        @(negedge clk);
        restart   = 1'b0;
    endtask

    function automatic int wdat();
        return int'($signed(wave_dat));
    endfunction

    task automatic t_reset();
        chk(wave_val == 1'b0 && wave_dat == '0, "R1 reset output idle", int'(wave_val), 0);
        chk(tbl_rden == 1'b0, "R1 reset no table read", int'(tbl_rden), 0);
        chk(act_mode == 2'd0 && act_freq == '0, "R2 reset active copy", int'(act_mode), 0);
    endtask

    task automatic t_no_restart();
        @(negedge clk);
        cfg_mode = 2'd3; cfg_freq = 18'd1234; cfg_ampl = 10'd300;
        cfg_count = 7'd9; cfg_phase = 9'd77;
        repeat (5) @(negedge clk);
        chk(act_mode == 2'd0, "R2 mode held without restart", int'(act_mode), 0);
        chk(act_freq == '0 && act_ampl == '0 && act_phase == '0, "R2 settings held",
            int'(act_freq), 0);
        chk(wave_val == 1'b0 && tbl_rden == 1'b0, "R2 no start without restart",
            int'(wave_val), 0);
    endtask

    task automatic t_play(input int mode, input int cnt, input int ampl, input int n_eff,
                          input int n_obs, input string tag);
        do_restart(mode, 0, ampl, cnt, 0);
        chk(act_mode == 2'(mode) && act_count == 7'(cnt) && act_ampl == 10'(ampl),
            "R2 active copy after restart", int'(act_mode), mode);
        repeat (2) @(negedge clk);
        for (int j = 0; j < n_obs; j++) begin
            int idx;
            if (n_eff == 0) begin
                chk(wave_val == 1'b0, {tag, " R6 empty count idle"}, int'(wave_val), 0);
            end else if (mode == 2 && j >= n_eff) begin
                chk(wave_val == 1'b0 && wave_dat == '0, {tag, " R4 stopped after N"},
                    int'(wave_val), 0);
            end else begin
                idx = j % n_eff;
                chk(wave_val == 1'b1, {tag, " R3 valid"}, int'(wave_val), 1);
                chk(wdat() == scaled(tbl[idx], ampl), {tag, " R9 data"}, wdat(),
                    scaled(tbl[idx], ampl));
                chk(wave_sync == (idx == 0), {tag, " R11 sync at index 0"},
                    int'(wave_sync), int'(idx == 0));
                chk(wave_ovr == clipped(tbl[idx], ampl), {tag, " R10 overflow flag"},
                    int'(wave_ovr), int'(clipped(tbl[idx], ampl)));
            end
            @(negedge clk);
        end
    endtask

    task automatic t_calc(input int f, input int p, input int n, input string tag);
        longint acc0;
        longint prev;
        longint cur;
        int     idx;
        do_restart(1, f, 256, 0, p);
        chk(act_freq == 18'(f) && act_phase == 9'(p), {tag, " R2 active step and phase"},
            int'(act_freq), f);
        repeat (2) @(negedge clk);
        acc0 = (longint'(p) * UNIT) / 360;
        prev = 0;
        for (int j = 0; j < n; j++) begin
            cur = (acc0 + longint'(j) * (f % UNIT)) % UNIT;
            idx = int'(cur >> 10);
            chk(wave_val == 1'b1 && wdat() == tbl[idx], {tag, " R7 computed sample"},
                wdat(), tbl[idx]);
            chk(wave_sync == (j == 0 || cur < prev), {tag, " R11 computed sync"},
                int'(wave_sync), int'(j == 0 || cur < prev));
            prev = cur;
            @(negedge clk);
        end
    endtask

    task automatic t_off();
        do_restart(3, 0, 256, 20, 0);
        repeat (10) @(negedge clk);
        do_restart(0, 0, 256, 20, 0);
        chk(act_mode == 2'd0, "R2 off mode captured", int'(act_mode), 0);
        chk(tbl_rden == 1'b0, "R1 off stops table reads", int'(tbl_rden), 0);
        repeat (2) @(negedge clk);
        for (int j = 0; j < 6; j++) begin
            chk(wave_val == 1'b0 && wave_dat == '0 && !wave_sync, "R1 off output idle",
                int'(wave_val), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            real r;
            r = 127.0 * $sin(2.0 * 3.14159265358979 * real'(k) / real'(DEPTH));
            tbl[k] = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_restart();
        t_play(2, 10, 256, 10, 16, "R4 one-shot N=10");
        t_play(3, 8, 256, 8, 26, "R5 looped N=8");
        t_play(2, 100, 256, 64, 70, "R6 one-shot clamp to 64");
        t_play(2, 0, 256, 0, 6, "R6 one-shot zero count");
        t_play(3, 0, 256, 0, 6, "R6 looped zero count");
        t_play(2, 64, 512, 64, 64, "R10 gain 2.0 clipping");
        t_play(3, 16, 128, 16, 20, "R9 gain 0.5 rounding");
        t_calc(UNIT / 2, 90, 10, "R7 half rate cosine");
        t_calc(UNIT / 2, 0, 10, "R7 half rate zero phase");
        t_calc(UNIT / 16, 0, 40, "R7 sixteenth rate");
        t_calc(UNIT, 45, 10, "R8 step equal to rate");
        t_calc(2 * UNIT, 45, 10, "R8 step twice rate");
        t_calc(UNIT / 16 + 2 * UNIT, 30, 20, "R8 alias of sixteenth rate");
        t_off();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule